// File: doc/BRIEF.md
# Bus Fault Status Register

This block sits beside a single-master processor bus. It watches every bus cycle for three kinds of fault. The first is a write into a chip-select region whose attribute marks it read-only. The second is a cycle that runs through the whole watchdog period without being acknowledged. The third is an address decode conflict. Each fault sets a sticky flag in one memory-mapped status register. Where the matching enable input is high, the fault also ends the cycle with a one-clock bus-error pulse. A write-protect fault also keeps the chip select low for the whole offending cycle.

The same register holds a two-bit code that records the source of the most recent reset or wakeup. The code is captured from an input when reset is released, and it is forced to the wakeup value when a wakeup event arrives. Software clears fault flags by writing ones. The reset-source code cannot be written. A processor-issued peripheral reset clears the fault flags but keeps the code. An access to the configuration registers never reports a decode conflict, so those registers can always be reached. Chip-select address matching is abstracted into per-cycle input flags.

A bus cycle lasts as long as `bus_valid_i` is high. The first clock with valid high after an idle clock or after a terminating clock is the start clock. The cycle terminates on the clock that has an acknowledge or a bus error.

Top module: `bus_fault_status`

## Requirements
- R1: The write-protect flag is register bit 0. It is set after the start clock of a write cycle with `cs_hit_i` and `cs_ro_i` high. `cs_o` is low for that whole cycle. Read cycles and writes to regions that are not read-only leave the flag alone, and `cs_o` follows `cs_hit_i` for them.
- R2: A write-protect fault with `wp_berr_en_i` high drives `berr_o` high for one clock, on the start clock. It does so even when bit 0 is already set. With the enable low, the flag is still set, no bus error is raised, and the cycle runs on to its acknowledge.
- R3: The watchdog flag is register bit 1. If a cycle has no acknowledge (external or internal) on its WDT_CYCLES-th clock, `berr_o` pulses on that clock and bit 1 is set. This repeats while bit 1 is already set. An acknowledge on that clock prevents both.
- R4: The decode-conflict flag is register bit 2. It is set by `decode_conflict_i` on a start clock. `berr_o` pulses on that clock only when `dc_berr_en_i` is high.
- R5: A decode conflict on a cycle with `cfg_access_i` high sets no flag and raises no bus error.
- R6: A register write with a one in bit 0, 1 or 2 clears that flag, and a zero leaves it unchanged. When a set event and a clear hit the same flag in the same clock, the set wins.
- R7: Register bits 5:4 hold the reset-source code: 00 power-on, 01 reset/halt pins, 10 software watchdog, 11 sleep wakeup. The code is loaded from `rst_code_i` on the first clock after reset release and ignores later changes of that input. A `wake_i` pulse loads 11.
- R8: Register writes never change bits 5:4. A `periph_rst_i` pulse clears bits 2:0 and leaves bits 5:4 unchanged.
- R9: Bits 3, 7 and 6 read zero whatever is written to them.
- R10: During reset, bits 2:0 and 5:4 read zero and `berr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus cycle in progress |
| bus_write_i | input | 1 | Cycle is a write |
| cs_hit_i | input | 1 | Address matches a chip-select region |
| cs_ro_i | input | 1 | Matched region is read-only |
| decode_conflict_i | input | 1 | Address decode conflict |
| cfg_access_i | input | 1 | Cycle targets the configuration registers |
| ack_ext_i | input | 1 | External acknowledge |
| ack_int_i | input | 1 | Internally generated acknowledge |
| wp_berr_en_i | input | 1 | Bus error on write-protect fault enable |
| dc_berr_en_i | input | 1 | Bus error on decode conflict enable |
| periph_rst_i | input | 1 | Processor-issued peripheral reset pulse |
| wake_i | input | 1 | Sleep wakeup event pulse |
| rst_code_i | input | 2 | Reset-source code sampled on reset release |
| reg_we_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | DATA_W | Status register write data |
| reg_rdata_o | output | DATA_W | Status register contents |
| cs_o | output | 1 | Chip select for the current cycle |
| berr_o | output | 1 | Bus-error pulse on the terminating clock |

## Verification
The bench sweeps every combination of write, chip-select hit, read-only, conflict and configuration access. It crosses these with all four settings of the two enables and four acknowledge timings: acknowledge on the start clock, an internal acknowledge mid-cycle, an acknowledge on the last watchdog clock, and no acknowledge at all. For each cycle it checks the terminating clock, the bus-error value, the chip select and all three flags. Together these tell an enabled fault apart from a recorded-only fault, an acknowledge that beats the watchdog apart from one that comes too late, and an exempt conflict apart from a reported one.

Directed sequences then cover the remaining cases:
- repeat faults while a flag is already set;
- partial and zero clear writes;
- a clear that coincides with a set;
- writes to the reserved bits and to the code field;
- a peripheral reset pulse;
- changes on the code input after it has been loaded;
- a wakeup event;
- a reset with each pin-driven code.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned WPV_BIT   = 0;
  localparam int unsigned HWT_BIT   = 1;
  localparam int unsigned DCF_BIT   = 2;
  localparam int unsigned SRC_LSB   = 4;
  localparam int unsigned SRC_W     = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_POWER_ON = 2'b00,
    SRC_PINS     = 2'b01,
    SRC_SW_DOG   = 2'b10,
    SRC_WAKEUP   = 2'b11
  } rst_src_e;
endpackage

// File: rtl/bfs_cycle_mon.sv
module bfs_cycle_mon #(
  parameter int unsigned WDT_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic write_i,
  input  logic hit_i,
  input  logic ro_i,
  input  logic conflict_i,
  input  logic cfg_i,
  input  logic ack_ext_i,
  input  logic ack_int_i,
  input  logic wp_en_i,
  input  logic dc_en_i,
  output logic start_o,
  output logic wp_evt_o,
  output logic dc_evt_o,
  output logic hwt_evt_o,
  output logic berr_o,
  output logic cs_o
);
  localparam int unsigned CNT_W = $clog2(WDT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WDT_CYCLES - 1);

  logic             in_cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur;
  logic             ack, ro_write, term;

  assign ack      = ack_ext_i | ack_int_i;
  assign ro_write = write_i & hit_i & ro_i;
  assign start_o  = valid_i & ~in_cyc_q;
  assign cur      = start_o ? '0 : cnt_q;

  assign wp_evt_o  = start_o & ro_write;
  assign dc_evt_o  = start_o & conflict_i & ~cfg_i;
  assign hwt_evt_o = valid_i & ~ack & (cur == LAST);

  assign berr_o = (wp_evt_o & wp_en_i) | (dc_evt_o & dc_en_i) | hwt_evt_o;
  assign term   = ack | berr_o;
  // chip select held off for the whole write-protected cycle
  assign cs_o   = valid_i & hit_i & ~(write_i & ro_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cyc_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      in_cyc_q <= valid_i & ~term;
      cnt_q    <= (valid_i & ~term) ? cur + CNT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/bfs_flag_bank.sv
module bfs_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q <= 1'b0;
      else if (set_i[i])            q <= 1'b1;  // set beats clear and flush
      else if (clr_i[i] | flush_i)  q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/bfs_rst_src.sv
module bfs_rst_src
  import bfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] code_i,
  input  logic             wake_i,
  output logic [SRC_W-1:0] code_o
);
  logic     loaded_q;
  rst_src_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      code_q   <= SRC_POWER_ON;
    end else begin
      loaded_q <= 1'b1;
      if (wake_i)         code_q <= SRC_WAKEUP;
      else if (!loaded_q) code_q <= rst_src_e'(code_i);
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/bus_fault_status.sv
module bus_fault_status
  import bfs_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WDT_CYCLES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              cs_hit_i,
  input  logic              cs_ro_i,
  input  logic              decode_conflict_i,
  input  logic              cfg_access_i,
  input  logic              ack_ext_i,
  input  logic              ack_int_i,
  input  logic              wp_berr_en_i,
  input  logic              dc_berr_en_i,
  input  logic              periph_rst_i,
  input  logic              wake_i,
  input  logic [SRC_W-1:0]  rst_code_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cs_o,
  output logic              berr_o
);
  logic                 cyc_start;
  logic                 wp_evt, dc_evt, hwt_evt;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;
  logic [SRC_W-1:0]     src_code;

  bfs_cycle_mon #(.WDT_CYCLES(WDT_CYCLES)) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (bus_valid_i),
    .write_i    (bus_write_i),
    .hit_i      (cs_hit_i),
    .ro_i       (cs_ro_i),
    .conflict_i (decode_conflict_i),
    .cfg_i      (cfg_access_i),
    .ack_ext_i  (ack_ext_i),
    .ack_int_i  (ack_int_i),
    .wp_en_i    (wp_berr_en_i),
    .dc_en_i    (dc_berr_en_i),
    .start_o    (cyc_start),
    .wp_evt_o   (wp_evt),
    .dc_evt_o   (dc_evt),
    .hwt_evt_o  (hwt_evt),
    .berr_o     (berr_o),
    .cs_o       (cs_o)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[WPV_BIT] = wp_evt;
    flag_set[HWT_BIT] = hwt_evt;
    flag_set[DCF_BIT] = dc_evt;
    flag_clr          = '0;
    flag_clr[WPV_BIT] = reg_we_i & reg_wdata_i[WPV_BIT];
    flag_clr[HWT_BIT] = reg_we_i & reg_wdata_i[HWT_BIT];
    flag_clr[DCF_BIT] = reg_we_i & reg_wdata_i[DCF_BIT];
  end

  bfs_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flush_i (periph_rst_i),
    .q_o     (flags)
  );

  bfs_rst_src u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (rst_code_i),
    .wake_i (wake_i),
    .code_o (src_code)
  );

  always_comb begin
    reg_rdata_o                    = '0;
    reg_rdata_o[WPV_BIT]           = flags[WPV_BIT];
    reg_rdata_o[HWT_BIT]           = flags[HWT_BIT];
    reg_rdata_o[DCF_BIT]           = flags[DCF_BIT];
    reg_rdata_o[SRC_LSB +: SRC_W]  = src_code;
  end
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker
  import bfs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_start,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic              cs_hit_i,
  input logic              cs_ro_i,
  input logic              decode_conflict_i,
  input logic              cfg_access_i,
  input logic              wp_berr_en_i,
  input logic              reg_we_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              wake_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              cs_o,
  input logic              berr_o
);
  logic armed_q;
  logic ro_wr;
  assign ro_wr = bus_write_i & cs_hit_i & cs_ro_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_WPV_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && ro_wr) |-> !cs_o); // R1
  AST_WPV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start && ro_wr) |=> reg_rdata_o[WPV_BIT]); // R1
  AST_WPV_BERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start && ro_wr && wp_berr_en_i) |-> berr_o); // R2
  AST_HWT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (berr_o && !cyc_start) |=> reg_rdata_o[HWT_BIT]); // R3
  AST_CFG_EXEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start && decode_conflict_i && cfg_access_i && !ro_wr) |-> !berr_o); // R5
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[WPV_BIT] && !(cyc_start && ro_wr)) |=> !reg_rdata_o[WPV_BIT]); // R6
  AST_WAKE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (reg_rdata_o[SRC_LSB +: SRC_W] == 2'b11)); // R7
  AST_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !wake_i) |=> $stable(reg_rdata_o[SRC_LSB +: SRC_W])); // R8
endmodule

bind bus_fault_status bfs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cyc_start         (cyc_start),
  .bus_valid_i       (bus_valid_i),
  .bus_write_i       (bus_write_i),
  .cs_hit_i          (cs_hit_i),
  .cs_ro_i           (cs_ro_i),
  .decode_conflict_i (decode_conflict_i),
  .cfg_access_i      (cfg_access_i),
  .wp_berr_en_i      (wp_berr_en_i),
  .reg_we_i          (reg_we_i),
  .reg_wdata_i       (reg_wdata_i),
  .wake_i            (wake_i),
  .reg_rdata_o       (reg_rdata_o),
  .cs_o              (cs_o),
  .berr_o            (berr_o)
);

// File: tb/bus_fault_status_bench.sv
module bus_fault_status_bench;
  localparam int WDT = 16;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid = 0, wr = 0, hit = 0, ro = 0, conf = 0, cfg = 0;
  logic ack_e = 0, ack_i = 0, wp_en = 0, dc_en = 0, prst = 0, wake = 0;
  logic [1:0] code = 2'b00;
  logic we = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic cs, berr;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bus_fault_status #(.DATA_W(DW), .WDT_CYCLES(WDT)) u_bus_fault_status (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(valid), .bus_write_i(wr),
    .cs_hit_i(hit), .cs_ro_i(ro), .decode_conflict_i(conf), .cfg_access_i(cfg),
    .ack_ext_i(ack_e), .ack_int_i(ack_i), .wp_berr_en_i(wp_en), .dc_berr_en_i(dc_en),
    .periph_rst_i(prst), .wake_i(wake), .rst_code_i(code), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cs_o(cs), .berr_o(berr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R act=running exp=done");
    report();
  end

  task automatic reg_write(input logic [DW-1:0] d);
    @(negedge clk); we = 1; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  // Runs one bus cycle; returns terminating clock index, bus error, cs on start clock
  task automatic run_cyc(input bit w, input bit h, input bit r, input bit cf, input bit cg,
                         input int ack_at, output int term_k, output bit be, output bit cs0);
    term_k = -1; be = 0; cs0 = 0;
    for (int k = 0; k < WDT + 4; k++) begin
      @(negedge clk);
      valid = 1; wr = w; hit = h; ro = r; conf = cf; cfg = cg;
      ack_e = (k == ack_at) && (ack_at != 3);
      ack_i = (k == ack_at) && (ack_at == 3);
      #2;
      if (k == 0) cs0 = cs;
      if (berr) be = 1;
      if (berr || ack_e || ack_i) begin term_k = k; break; end
    end
    @(negedge clk);
    valid = 0; wr = 0; hit = 0; ro = 0; conf = 0; cfg = 0; ack_e = 0; ack_i = 0;
  endtask

  task automatic do_reset(input logic [1:0] c);
    @(negedge clk); rst_ni = 0; code = c;
    @(negedge clk); #2;
    chk("R10 flags in reset", int'(rdata[2:0]), 0);
    chk("R10 code in reset", int'(rdata[5:4]), 0);
    chk("R10 berr in reset", int'(berr), 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk("R7 code loaded on release", int'(rdata[5:4]), int'(c));
  endtask

  initial begin
    int tk; bit be, cs0;
    int acks[4];
    acks[0] = 0; acks[1] = 3; acks[2] = WDT - 1; acks[3] = 999;
    do_reset(2'b01);

    // sweep: R1 R2 R3 R4 R5 R6
    for (int en = 0; en < 4; en++) begin
      for (int cmb = 0; cmb < 32; cmb++) begin
        for (int ai = 0; ai < 4; ai++) begin
          bit w, h, r, cf, cg, wpf, dcf, fb, hwt;
          int ek; bit eb;
          w = cmb[0]; h = cmb[1]; r = cmb[2]; cf = cmb[3]; cg = cmb[4];
          @(negedge clk); wp_en = en[0]; dc_en = en[1];
          wpf = w && h && r;
          dcf = cf && !cg;
          fb  = (wpf && en[0]) || (dcf && en[1]);
          hwt = 0;
          if (fb) begin ek = 0; eb = 1; end
          else if (acks[ai] < WDT) begin ek = acks[ai]; eb = 0; end
          else begin ek = WDT - 1; eb = 1; hwt = 1; end
          run_cyc(w, h, r, cf, cg, acks[ai], tk, be, cs0);
          chk("R2/R3/R4 term clock", tk, ek);
          chk("R2/R3/R4 berr", int'(be), int'(eb));
          chk("R1 cs on start", int'(cs0), int'(h && !(w && r)));
          chk("R1 wp flag", int'(rdata[0]), int'(wpf));
          chk("R3 hwt flag", int'(rdata[1]), int'(hwt));
          chk("R4 R5 conflict flag", int'(rdata[2]), int'(dcf));
          reg_write(8'h07);
          chk("R6 clear all", int'(rdata[2:0]), 0);
        end
      end
    end

    // R2 repeat violation with flag set
    @(negedge clk); wp_en = 1; dc_en = 0;
    run_cyc(1, 1, 1, 0, 0, 999, tk, be, cs0);
    run_cyc(1, 1, 1, 0, 0, 999, tk, be, cs0);
    chk("R2 repeat berr", int'(be), 1);
    chk("R2 repeat term", tk, 0);
    // R3 repeat timeout with flag set
    run_cyc(0, 0, 0, 0, 0, 999, tk, be, cs0);
    run_cyc(0, 0, 0, 0, 0, 999, tk, be, cs0);
    chk("R3 repeat berr", int'(be), 1);
    chk("R3 repeat term", tk, WDT - 1);
    // R6 partial clears
    @(negedge clk); wp_en = 0;
    run_cyc(1, 1, 1, 1, 0, 999, tk, be, cs0);
    chk("R6 all flags set", int'(rdata[2:0]), 7);
    reg_write(8'h00);
    chk("R6 zero write keeps", int'(rdata[2:0]), 7);
    reg_write(8'h02);
    chk("R6 clear bit1 only", int'(rdata[2:0]), 5);
    reg_write(8'h05);
    chk("R6 clear rest", int'(rdata[2:0]), 0);
    // R6 set wins over coincident clear
    @(negedge clk); wp_en = 1; we = 1; wdata = 8'h01;
    valid = 1; wr = 1; hit = 1; ro = 1;
    @(negedge clk); we = 0; wdata = '0; valid = 0; wr = 0; hit = 0; ro = 0;
    chk("R6 set wins", int'(rdata[0]), 1);
    // R9 R8 reserved bits and code field ignore writes
    reg_write(8'hFF);
    chk("R9 reserved zero", int'(rdata & 8'hC8), 0);
    chk("R8 code unchanged by write", int'(rdata[5:4]), 1);
    reg_write(8'h30);
    chk("R8 code unchanged by write 2", int'(rdata[5:4]), 1);
    // R8 peripheral reset
    run_cyc(1, 1, 1, 1, 0, 999, tk, be, cs0);
    @(negedge clk); prst = 1;
    @(negedge clk); prst = 0;
    chk("R8 periph reset clears flags", int'(rdata[2:0]), 0);
    chk("R8 periph reset keeps code", int'(rdata[5:4]), 1);
    // R7 later input change ignored, wakeup loads 11
    @(negedge clk); code = 2'b10;
    @(negedge clk); @(negedge clk);
    chk("R7 code ignores input after load", int'(rdata[5:4]), 1);
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0;
    chk("R7 wakeup code", int'(rdata[5:4]), 3);
    // R7 each pin code across resets
    for (int c = 0; c < 3; c++) do_reset(2'(c));
    report();
  end
endmodule